// File: doc/BRIEF.md
# Lockable Network Controller Register Bank

This block is the byte-wide control and status register file of a network controller. Software reaches it over a plain register bus: an 8-bit address, a write strobe, a write byte and a combinational read byte. It holds a command byte that enables the receive and transmit paths and starts a soft reset. It also holds a key-protected station (MAC) address, an interrupt status word with its mask, and a single interrupt line.

A write with the soft-reset bit set starts an internal sequence of fixed length. For that whole time the reset bit reads back as 1 and the `srst` output is high. While the sequence runs, both path enables are forced off and the interrupt status is held at zero. When the sequence ends, the reset bit clears by itself. The sequence does not touch the station address, the lock or the mask. The station address can only be written after the lock register is given the unlock key. Hardware event pulses set interrupt status bits, and software clears them by writing ones.

Top module: `netctl_regbank`

## Requirements
- R1: After reset, rx_en, tx_en, srst and irq are 0. The lock register reads 0x00 (locked). The station address, the interrupt status (0x3E/0x3F) and the mask (0x3C/0x3D) all read 0.
- R2: The command byte is at 0x37. Bit 3 is receive enable and drives rx_en. Bit 2 is transmit enable and drives tx_en. Both take effect on the clock edge of the write and read back in place. Writing 0x00 clears both.
- R3: Command bit 0 is read-only and mirrors the rxbuf_empty input. Writing it has no effect.
- R4: Writing a byte with bit 4 set to 0x37 starts the soft reset. Bit 4 reads 1 and srst is high for exactly RST_CYCLES (default 16) cycles after the write edge, then both return to 0 by themselves.
- R5: During the soft reset, rx_en and tx_en are 0 and command writes are ignored. Afterwards, both enables stay 0 until software sets them again.
- R6: The soft reset clears the interrupt status, and event inputs are ignored while it runs. The station address, the lock state and the interrupt mask keep their values.
- R7: The lock register is at 0x50. Writing 0xC0 unlocks it, and it then reads 0xC0. Writing 0x00 locks it, and it then reads 0x00. Any other value leaves the state unchanged.
- R8: Station address byte i (0..5) is at address i and drives mac_addr[8i+7:8i]. A write takes effect only while the bank is unlocked. While locked, writes are ignored and reads return the held byte.
- R9: Interrupt status is 16 bits, with the low byte at 0x3E and the high byte at 0x3F. Event inputs map as follows: evt[0] sets bit 0 (receive OK), evt[1] sets bit 2 (transmit OK), evt[2] sets bit 6 (receive FIFO overflow), evt[3] sets bit 7 (transmit descriptor unavailable) and evt[4] sets bit 15 (system error). A bit is set from the edge that samples its event. All other bits read 0.
- R10: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If an event and a clear of the same bit arrive in the same cycle, the bit stays set.
- R11: The mask is 16 bits, with the low byte at 0x3C and the high byte at 0x3D, and is read/write. irq is 1 exactly when some status bit and its mask bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte (combinational from bus_addr) |
| rxbuf_empty | input | 1 | Receive buffer empty flag from the datapath |
| evt | input | 5 | Event pulses: rx ok, tx ok, rx FIFO overflow, tx desc unavailable, system error |
| rx_en | output | 1 | Receive path enable |
| tx_en | output | 1 | Transmit path enable |
| srst | output | 1 | High while the soft reset sequence runs |
| irq | output | 1 | Masked interrupt request |
| mac_addr | output | 48 | Station address |

## Verification
A wrong sequence counter shows up at once as a reset bit and srst level whose length differs from the required number of cycles. The bench counts that length one cycle at a time. A broken lock leaks onto mac_addr on the clock edge after a locked write. A wrong status bit mapping or a wrong clear priority shows in the status read-back one cycle after the stimulus. Irq follows the same status word, so any error in the mask or status path reaches irq in that same cycle.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int unsigned AW       = 8;
  localparam int unsigned DW       = 8;
  localparam int unsigned MAC_BYTES = 6;
  localparam int unsigned NUM_EVT  = 5;
  localparam int unsigned STAT_W   = 16;

  localparam logic [AW-1:0] A_CMD     = 8'h37;
  localparam logic [AW-1:0] A_LOCK    = 8'h50;
  localparam logic [AW-1:0] A_MASK_LO = 8'h3C;
  localparam logic [AW-1:0] A_MASK_HI = 8'h3D;
  localparam logic [AW-1:0] A_STAT_LO = 8'h3E;
  localparam logic [AW-1:0] A_STAT_HI = 8'h3F;

  localparam logic [DW-1:0] KEY_OPEN  = 8'hC0;
  localparam logic [DW-1:0] KEY_CLOSE = 8'h00;

  localparam int unsigned CMD_RST = 4;
  localparam int unsigned CMD_RXE = 3;
  localparam int unsigned CMD_TXE = 2;
  localparam int unsigned CMD_RBE = 0;

  // status bit fed by each event input, in event index order
  localparam int unsigned EVT_BIT [NUM_EVT] = '{0, 2, 6, 7, 15};
endpackage

// File: rtl/regbank_cmd.sv
module regbank_cmd
  import regbank_pkg::*;
#(
  parameter int unsigned RST_CYCLES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_cmd,
  input  logic [DW-1:0] wdata,
  output logic          busy,
  output logic          rx_en,
  output logic          tx_en
);
  localparam int unsigned CW = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(RST_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          rx_q, rx_d, tx_q, tx_d;
  logic          cnt_en, en_en;

  assign busy = (cnt_q != '0);

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    en_en  = 1'b0;
    rx_d   = rx_q;
    tx_d   = tx_q;
    if (busy) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
      en_en  = 1'b1;
      rx_d   = 1'b0;
      tx_d   = 1'b0;
    end else if (wr_cmd) begin
      en_en = 1'b1;
      if (wdata[CMD_RST]) begin
        cnt_en = 1'b1;
        cnt_d  = CNT_LOAD;
        rx_d   = 1'b0;
        tx_d   = 1'b0;
      end else begin
        rx_d = wdata[CMD_RXE];
        tx_d = wdata[CMD_TXE];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= 1'b0;
      tx_q <= 1'b0;
    end else if (en_en) begin
      rx_q <= rx_d;
      tx_q <= tx_d;
    end
  end

  assign rx_en = rx_q;
  assign tx_en = tx_q;

  // R4
  rst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && wdata[CMD_RST] && !busy) |=> busy);
  // R5
  en_off_in_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!rx_en && !tx_en));
endmodule

// File: rtl/regbank_lock.sv
module regbank_lock
  import regbank_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_lock,
  input  logic [MAC_BYTES-1:0]   wr_mac,
  input  logic [DW-1:0]          wdata,
  output logic                   unlocked,
  output logic [MAC_BYTES*DW-1:0] mac
);
  logic open_q, open_d, open_en;

  always_comb begin
    open_en = 1'b0;
    open_d  = open_q;
    if (wr_lock && wdata == KEY_OPEN) begin
      open_en = 1'b1;
      open_d  = 1'b1;
    end else if (wr_lock && wdata == KEY_CLOSE) begin
      open_en = 1'b1;
      open_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
    end else if (open_en) begin
      open_q <= open_d;
    end
  end

  assign unlocked = open_q;

  for (genvar b = 0; b < MAC_BYTES; b++) begin : g_mac
    logic [DW-1:0] byte_q;
    logic          byte_en;
    assign byte_en = wr_mac[b] && open_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '0;
      end else if (byte_en) begin
        byte_q <= wdata;
      end
    end
    assign mac[b*DW +: DW] = byte_q;
  end

  // R8
  mac_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && (wr_mac != '0)) |=> $stable(mac));
endmodule

// File: rtl/regbank_irq.sv
module regbank_irq
  import regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic [NUM_EVT-1:0] evt,
  input  logic [1:0]        wr_stat,
  input  logic [1:0]        wr_mask,
  input  logic [DW-1:0]     wdata,
  output logic [STAT_W-1:0] status,
  output logic [STAT_W-1:0] mask,
  output logic              irq
);
  logic [STAT_W-1:0] set_v, clr_v, impl_v, stat_q, stat_d, mask_q, mask_d;
  logic              mask_en;

  always_comb begin
    set_v  = '0;
    impl_v = '0;
    for (int i = 0; i < NUM_EVT; i++) begin
      impl_v[EVT_BIT[i]] = 1'b1;
      set_v[EVT_BIT[i]]  = evt[i];
    end
  end

  always_comb begin
    clr_v = '0;
    if (wr_stat[0]) clr_v[DW-1:0]      = wdata;
    if (wr_stat[1]) clr_v[STAT_W-1:DW] = wdata;
    if (busy) stat_d = '0;
    else      stat_d = ((stat_q & ~clr_v) | set_v) & impl_v;
  end

  always_comb begin
    mask_en = |wr_mask;
    mask_d  = mask_q;
    if (wr_mask[0]) mask_d[DW-1:0]      = wdata;
    if (wr_mask[1]) mask_d[STAT_W-1:DW] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else begin
      stat_q <= stat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  assign status = stat_q;
  assign mask   = mask_q;
  assign irq    = |(stat_q & mask_q);

  for (genvar e = 0; e < NUM_EVT; e++) begin : g_chk
    // R10
    evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && evt[e]) |=> status[EVT_BIT[e]]);
  end
  // R6
  rst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (status == '0));
endmodule

// File: rtl/netctl_regbank.sv
module netctl_regbank
  import regbank_pkg::*;
#(
  parameter int unsigned RST_CYCLES = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [7:0]              bus_addr,
  input  logic                    bus_wr,
  input  logic [7:0]              bus_wdata,
  output logic [7:0]              bus_rdata,
  input  logic                    rxbuf_empty,
  input  logic [4:0]              evt,
  output logic                    rx_en,
  output logic                    tx_en,
  output logic                    srst,
  output logic                    irq,
  output logic [47:0]             mac_addr
);
  logic rst_s1, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  logic                    wr_cmd, wr_lock, busy, unlocked;
  logic [MAC_BYTES-1:0]    wr_mac;
  logic [1:0]              wr_stat, wr_mask;
  logic [STAT_W-1:0]       status, mask;

  always_comb begin
    wr_cmd  = bus_wr && (bus_addr == A_CMD);
    wr_lock = bus_wr && (bus_addr == A_LOCK);
    wr_stat = {bus_wr && (bus_addr == A_STAT_HI), bus_wr && (bus_addr == A_STAT_LO)};
    wr_mask = {bus_wr && (bus_addr == A_MASK_HI), bus_wr && (bus_addr == A_MASK_LO)};
    for (int b = 0; b < MAC_BYTES; b++) wr_mac[b] = bus_wr && (bus_addr == AW'(b));
  end

  regbank_cmd #(.RST_CYCLES(RST_CYCLES)) u_cmd (
    .clk(clk), .rst_n(rst_sync_n), .wr_cmd(wr_cmd), .wdata(bus_wdata),
    .busy(busy), .rx_en(rx_en), .tx_en(tx_en)
  );

  regbank_lock u_lock (
    .clk(clk), .rst_n(rst_sync_n), .wr_lock(wr_lock), .wr_mac(wr_mac),
    .wdata(bus_wdata), .unlocked(unlocked), .mac(mac_addr)
  );

  regbank_irq u_irq (
    .clk(clk), .rst_n(rst_sync_n), .busy(busy), .evt(evt), .wr_stat(wr_stat),
    .wr_mask(wr_mask), .wdata(bus_wdata), .status(status), .mask(mask), .irq(irq)
  );

  assign srst = busy;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr < AW'(MAC_BYTES)) begin
      bus_rdata = mac_addr[bus_addr[2:0]*DW +: DW];
    end else begin
      case (bus_addr)
        A_CMD: begin
          bus_rdata[CMD_RST] = busy;
          bus_rdata[CMD_RXE] = rx_en;
          bus_rdata[CMD_TXE] = tx_en;
          bus_rdata[CMD_RBE] = rxbuf_empty;
        end
        A_LOCK:    bus_rdata = unlocked ? KEY_OPEN : KEY_CLOSE;
        A_MASK_LO: bus_rdata = mask[DW-1:0];
        A_MASK_HI: bus_rdata = mask[STAT_W-1:DW];
        A_STAT_LO: bus_rdata = status[DW-1:0];
        A_STAT_HI: bus_rdata = status[STAT_W-1:DW];
        default:   bus_rdata = '0;
      endcase
    end
  end

  // R11
  irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mask == '0) |-> !irq);
endmodule

// File: tb/sim_netctl_regbank.sv
module sim_netctl_regbank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr, bus_wdata, bus_rdata;
  logic        bus_wr, rxbuf_empty;
  logic [4:0]  evt;
  logic        rx_en, tx_en, srst, irq;
  logic [47:0] mac_addr;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  netctl_regbank u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rxbuf_empty(rxbuf_empty),
    .evt(evt), .rx_en(rx_en), .tx_en(tx_en), .srst(srst), .irq(irq),
    .mac_addr(mac_addr)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  // bus write: driven at negedge, captured at next posedge, released at negedge
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic t_reset_state();
    logic [7:0] d;
    chk("R1 rx_en", rx_en, 0); chk("R1 tx_en", tx_en, 0);
    chk("R1 srst", srst, 0);   chk("R1 irq", irq, 0);
    chk("R1 mac", mac_addr, 0);
    rd(8'h50, d); chk("R1 lock", d, 8'h00);
    rd(8'h3E, d); chk("R1 stat lo", d, 0);
    rd(8'h3F, d); chk("R1 stat hi", d, 0);
    rd(8'h3C, d); chk("R1 mask lo", d, 0);
  endtask

  task automatic t_cmd();
    logic [7:0] d;
    wr(8'h37, 8'h08);
    chk("R2 rx only", {rx_en, tx_en}, 2'b10);
    wr(8'h37, 8'h0C);
    rd(8'h37, d); chk("R2 readback", d & 8'h0C, 8'h0C);
    chk("R2 both", {rx_en, tx_en}, 2'b11);
    wr(8'h37, 8'h00);
    chk("R2 stop", {rx_en, tx_en}, 2'b00);
    rxbuf_empty = 1'b1; rd(8'h37, d); chk("R3 mirror 1", d, 8'h01);
    wr(8'h37, 8'h01);
    rxbuf_empty = 1'b0; rd(8'h37, d); chk("R3 write ignored", d, 8'h00);
  endtask

  task automatic t_lock_mac();
    logic [7:0] d;
    wr(8'h00, 8'hAA);
    chk("R8 locked write", mac_addr, 0);
    wr(8'h50, 8'h55);
    rd(8'h50, d); chk("R7 bad key", d, 8'h00);
    wr(8'h50, 8'hC0);
    rd(8'h50, d); chk("R7 unlock", d, 8'hC0);
    for (int i = 0; i < 6; i++) wr(8'(i), 8'(8'h10 + i));
    chk("R8 mac", mac_addr, 48'h151413121110);
    wr(8'h50, 8'h33);
    rd(8'h50, d); chk("R7 other value keeps", d, 8'hC0);
    wr(8'h50, 8'h00);
    rd(8'h50, d); chk("R7 relock", d, 8'h00);
    wr(8'h03, 8'hEE);
    rd(8'h03, d); chk("R8 held byte", d, 8'h13);
    chk("R8 mac kept", mac_addr, 48'h151413121110);
  endtask

  task automatic t_irq();
    logic [7:0] lo, hi;
    @(negedge clk); evt = 5'b11111;
    @(negedge clk); evt = 5'b00000;
    rd(8'h3E, lo); rd(8'h3F, hi);
    chk("R9 status all", {hi, lo}, 16'h80C5);
    chk("R11 unmasked no irq", irq, 0);
    wr(8'h3D, 8'h80);
    chk("R11 irq on mask", irq, 1);
    wr(8'h3F, 8'h80);
    chk("R10 w1c hi", irq, 0);
    wr(8'h3E, 8'h01);
    rd(8'h3E, lo); chk("R10 w1c lo keeps others", lo, 8'hC4);
    // same-cycle clear and event
    @(negedge clk);
    bus_addr = 8'h3E; bus_wdata = 8'h04; bus_wr = 1'b1; evt = 5'b00010;
    @(negedge clk);
    bus_wr = 1'b0; evt = 5'b0;
    rd(8'h3E, lo); chk("R10 event wins", lo, 8'hC4);
    wr(8'h3E, 8'h00);
    rd(8'h3E, lo); chk("R10 zero write", lo, 8'hC4);
    wr(8'h3C, 8'h40);
    chk("R11 irq lo mask", irq, 1);
  endtask

  task automatic t_soft_reset();
    logic [7:0] d;
    int ones;
    wr(8'h50, 8'hC0);
    wr(8'h37, 8'h0C);
    wr(8'h37, 8'h10);
    chk("R4 srst high", srst, 1);
    chk("R5 enables off", {rx_en, tx_en}, 2'b00);
    bus_addr = 8'h37; bus_wdata = 8'h0C; bus_wr = 1'b1; evt = 5'b11111;
    ones = 0;
    for (int c = 0; c < 20; c++) begin
      rd(8'h37, d);
      if (d[4]) ones++;
      if (d[4] && (rx_en || tx_en)) chk("R5 enable during reset", {rx_en, tx_en}, 0);
      @(negedge clk);
      if (c == 14) begin bus_wr = 1'b0; evt = 5'b0; end
    end
    chk("R4 reset length", ones, 16);
    chk("R4 srst low", srst, 0);
    chk("R5 enables stay off", {rx_en, tx_en}, 2'b00);
    rd(8'h3E, d); chk("R6 status cleared lo", d, 0);
    rd(8'h3F, d); chk("R6 status cleared hi", d, 0);
    rd(8'h50, d); chk("R6 lock kept", d, 8'hC0);
    rd(8'h3C, d); chk("R6 mask kept", d, 8'h40);
    chk("R6 mac kept", mac_addr, 48'h151413121110);
    wr(8'h37, 8'h04);
    chk("R5 enable after reset", {rx_en, tx_en}, 2'b01);
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = 0; bus_wdata = 0; bus_wr = 0;
    rxbuf_empty = 0; evt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_state();
    t_cmd();
    t_lock_mac();
    t_irq();
    t_soft_reset();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule